// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single channel of a programmable interval timer. A host-side register block hands it a three-bit operating mode and a decimal-count select through a configuration strobe, and a 16-bit initial count through a separate count strobe. The channel then turns its clock and a GATE input into an OUT waveform. The six waveforms are a terminal-count flag, a retriggerable one-shot, a divide-by-N rate pulse, a square wave and two single-clock strobes, one started by software and one by hardware. The live counter value and a flag marking an unloaded count are returned to the host side.

GATE passes through a two-flop synchroniser, and its rising edge is detected in the clock domain. All state changes on the rising edge of the clock. A count-only write never resets the channel's configuration. Depending on the mode, the new count is loaded on the next clock, at the next reload, or at the next trigger. The counter steps in plain binary or as four packed decimal digits. A loaded count of zero means the largest count.

Top module: `tmr_channel`

## Requirements
- R1: After reset OUT is high, the live count is 0 and the null-count flag is 0.
- R2: A count write sets the null-count flag on the next clock. The flag clears on the clock that copies the written value into the counter, and the live count then shows the counter value as it decrements.
- R3: Mode code 0 (terminal flag): OUT goes low at the write, the counter loads on the following clock and then decrements once per clock while the synchronised GATE is high. OUT therefore rises N+1 clocks after the write edge. While GATE is low, both the count and OUT hold.
- R4: Mode code 1 (one-shot): a count write alone starts nothing. A GATE rising edge loads the count and drives OUT low at the third clock edge after GATE rises. OUT stays low for N clocks. A count written during the pulse leaves that pulse unchanged and applies to the next trigger, and a trigger during the pulse restarts the N-clock pulse.
- R5: Mode code 2 (rate): OUT is low for exactly one clock, while the count equals 1, and then the count reloads, giving a period of N clocks. The first low clock comes N clocks after the write edge. N must be at least 2.
- R6: Mode code 3 (square wave): after the write, OUT stays high for 1+ceil(N/2) clocks, then alternates between floor(N/2) clocks low and ceil(N/2) clocks high. N must be at least 2.
- R7: In modes 2 and 3, a low synchronised GATE forces OUT high and freezes the count. A GATE rising edge reloads the count at the third clock edge, so the next low pulse of mode 2 begins N+2 clocks after GATE rises.
- R8: Mode code 4 (software strobe): OUT goes low for exactly one clock, N+1 clocks after the write edge, and does not pulse again until the next count write.
- R9: Mode code 5 (hardware strobe): a count write alone does not start counting. After a GATE rising edge, OUT goes low for one clock N+3 clocks after GATE rises.
- R10: With the decimal select bit at 1, the count is four packed decimal digits, one per nibble with the least significant digit in bits 3:0, and each step borrows across digits (0x0100 is followed by 0x0099, and 0x0000 by 0x9999).
- R11: A loaded count of 0 acts as 65536 in binary and 10000 in decimal, so a mode 2 period is 65536 or 10000 clocks.
- R12: Mode codes 6 and 7 behave as codes 2 and 3.
- R13: A configuration write sets OUT to its initial level, low for mode 0 and high for all others. It also sets the null-count flag and discards any count loaded earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_i | input | 1 | Asynchronous GATE input (enable or trigger, depending on mode) |
| cfg_wr_i | input | 1 | One-clock strobe that captures mode and decimal select |
| mode_i | input | 3 | Operating mode code 0 to 7 |
| bcd_i | input | 1 | 1 selects four-digit decimal counting |
| cnt_wr_i | input | 1 | One-clock strobe that captures the initial count |
| count_i | input | 16 | Initial count value |
| out_o | output | 1 | Timer output waveform |
| count_o | output | 16 | Live counter value |
| null_o | output | 1 | High while a written count has not yet been loaded |

## Verification
Every mode is swept over a run of small counts, and the bench measures OUT's low and high widths against N+1, N, floor(N/2) and ceil(N/2). These sweeps separate off-by-one load timing from wrong reload points, and show whether odd counts in square-wave mode are split correctly between the two halves. The GATE patterns are: held high, dropped mid-count, pulsed before the count, retriggered mid-pulse, and held steady while a count is rewritten. These patterns distinguish gating, retriggering and deferred loading. Decimal borrow chains and zero counts in both number systems check the step arithmetic at its wrap points.

// File: rtl/tmr_chan_pkg.sv
// Shared mode encoding for the timer channel.
// Assumes the host hands over a raw 3-bit code; codes 6 and 7 fold onto 2 and 3.
package tmr_chan_pkg;

    typedef enum logic [2:0] {
        MD_TERMINAL  = 3'd0,
        MD_ONESHOT   = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } tmr_mode_e;

    // Map a raw mode code onto one of the six supported modes.
    function automatic tmr_mode_e fold_mode(input logic [2:0] code);
        if (code[1]) begin
            return tmr_mode_e'({1'b0, code[1:0]});
        end
        return tmr_mode_e'(code);
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
// GATE synchroniser and rising-edge detector.
// Assumes gate_i is asynchronous to clk; level_o lags it by STAGES clocks and
// rise_o is a single-cycle pulse on the first clock where level_o is high.
module tmr_gate_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              level_d;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of GATE.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= gate_i;
            end
        end else begin : g_chain
            // Shift GATE through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], gate_i};
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= sync_q[STAGES-1];
    end

    assign level_o = sync_q[STAGES-1];
    assign rise_o  = level_o & ~level_d;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R4

endmodule

// File: rtl/tmr_count_step.sv
// Combinational down-step of the counter by 1, 2 or 3 in binary or packed BCD.
// Assumes BCD inputs hold valid digits; wrap below zero goes to all ones / all nines.
module tmr_count_step #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] val_i,
    input  logic [1:0]          amt_i,
    input  logic                bcd_i,
    output logic [4*DIGITS-1:0] nxt_o
);

    localparam int W = 4 * DIGITS;

    logic [W-1:0] bin_nxt;
    logic [W-1:0] dec_nxt;
    logic [1:0]   borrow;
    logic [4:0]   diff;

    assign bin_nxt = val_i - W'(amt_i);

    // Ripple the borrow through the decimal digits, low digit first.
    always_comb begin
        borrow  = amt_i;
        dec_nxt = '0;
        diff    = '0;
        for (int d = 0; d < DIGITS; d++) begin
            diff = {1'b0, val_i[4*d +: 4]} - {3'b000, borrow};
            if (diff[4]) begin
                dec_nxt[4*d +: 4] = diff[3:0] + 4'd10;
                borrow            = 2'd1;
            end else begin
                dec_nxt[4*d +: 4] = diff[3:0];
                borrow            = 2'd0;
            end
        end
    end

    assign nxt_o = bcd_i ? dec_nxt : bin_nxt;

endmodule

// File: rtl/tmr_channel.sv
// One programmable down-counter channel of an interval timer.
// Host side gives a config strobe (mode, decimal select) and a count strobe;
// the channel loads, gates, reloads and shapes OUT per mode. Assumes both
// strobes are single-cycle and synchronous to clk; GATE may be asynchronous.
module tmr_channel
    import tmr_chan_pkg::*;
#(
    parameter int COUNT_W   = 16,
    parameter int GATE_SYNC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_i,
    input  logic               cfg_wr_i,
    input  logic [2:0]         mode_i,
    input  logic               bcd_i,
    input  logic               cnt_wr_i,
    input  logic [COUNT_W-1:0] count_i,
    output logic               out_o,
    output logic [COUNT_W-1:0] count_o,
    output logic               null_o
);

    localparam int                 DIGITS = COUNT_W / 4;
    localparam logic [COUNT_W-1:0] ONE    = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] TWO    = COUNT_W'(2);

    tmr_mode_e          mode_q, cfg_mode;
    logic               bcd_q;
    logic [COUNT_W-1:0] cnt_q, pend_q, step_nxt;
    logic               loaded_q, fired_q, first_q, odd_q, out_q;
    logic               pend_ld_q, null_q, has_cnt_q;
    logic               gate_lvl, gate_rise;
    logic               is_strobe, is_wave, trig_mode, count_en, load_now;
    logic [1:0]         step_amt;

    tmr_gate_edge #(.STAGES(GATE_SYNC)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_i  (gate_i),
        .level_o (gate_lvl),
        .rise_o  (gate_rise)
    );

    tmr_count_step #(.DIGITS(DIGITS)) u_step (
        .val_i (cnt_q),
        .amt_i (step_amt),
        .bcd_i (bcd_q),
        .nxt_o (step_nxt)
    );

    // Mode classes, count enable and the load decision.
    always_comb begin
        cfg_mode  = fold_mode(mode_i);
        is_strobe = (mode_q == MD_SW_STROBE) || (mode_q == MD_HW_STROBE);
        is_wave   = (mode_q == MD_RATE) || (mode_q == MD_SQUARE);
        trig_mode = (mode_q != MD_TERMINAL) && (mode_q != MD_SW_STROBE);
        count_en  = ((mode_q == MD_ONESHOT) || (mode_q == MD_HW_STROBE)) ? 1'b1 : gate_lvl;
        load_now  = !cfg_wr_i && (pend_ld_q || (gate_rise && has_cnt_q && trig_mode));
        if (mode_q == MD_SQUARE) begin
            if (odd_q && first_q) step_amt = out_q ? 2'd1 : 2'd3;
            else                  step_amt = 2'd2;
        end else begin
            step_amt = 2'd1;
        end
    end

    // Host-side holding register, deferred-load request and null flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            pend_ld_q <= 1'b0;
            null_q    <= 1'b0;
            has_cnt_q <= 1'b0;
        end else if (cfg_wr_i) begin
            pend_ld_q <= 1'b0;
            has_cnt_q <= 1'b0;
            null_q    <= 1'b1;
        end else if (cnt_wr_i) begin
            pend_q    <= count_i;
            null_q    <= 1'b1;
            has_cnt_q <= 1'b1;
            pend_ld_q <= (mode_q == MD_TERMINAL) || (mode_q == MD_SW_STROBE)
                      || (is_wave && !loaded_q) || (pend_ld_q && !load_now);
        end else if (load_now) begin
            pend_ld_q <= 1'b0;
            null_q    <= 1'b0;
        end
    end

    // Counter, reload and OUT waveform per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_TERMINAL;
            bcd_q    <= 1'b0;
            cnt_q    <= '0;
            odd_q    <= 1'b0;
            loaded_q <= 1'b0;
            fired_q  <= 1'b0;
            first_q  <= 1'b0;
            out_q    <= 1'b1;
        end else if (cfg_wr_i) begin
            mode_q   <= cfg_mode;
            bcd_q    <= bcd_i;
            out_q    <= (cfg_mode != MD_TERMINAL);
            loaded_q <= 1'b0;
            fired_q  <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            if (is_strobe && !out_q) out_q <= 1'b1;
            if (load_now) begin
                cnt_q    <= pend_q;
                odd_q    <= pend_q[0];
                loaded_q <= 1'b1;
                fired_q  <= 1'b0;
                first_q  <= 1'b1;
                out_q    <= !((mode_q == MD_TERMINAL) || (mode_q == MD_ONESHOT));
            end else if (loaded_q && count_en) begin
                unique case (mode_q)
                    MD_RATE: begin
                        if (cnt_q == ONE) begin
                            cnt_q <= pend_q;
                            odd_q <= pend_q[0];
                            out_q <= 1'b1;
                        end else begin
                            cnt_q <= step_nxt;
                            if (cnt_q == TWO) out_q <= 1'b0;
                        end
                    end
                    MD_SQUARE: begin
                        if (cnt_q == COUNT_W'(step_amt)) begin
                            cnt_q   <= pend_q;
                            odd_q   <= pend_q[0];
                            out_q   <= !out_q;
                            first_q <= 1'b1;
                        end else begin
                            cnt_q   <= step_nxt;
                            first_q <= 1'b0;
                        end
                    end
                    default: begin
                        cnt_q <= step_nxt;
                        if (cnt_q == ONE && !fired_q) begin
                            fired_q <= 1'b1;
                            out_q   <= !is_strobe;
                        end
                    end
                endcase
            end
            if (is_wave && !gate_lvl) out_q <= 1'b1;
            if (cnt_wr_i && mode_q == MD_TERMINAL) out_q <= 1'b0;
        end
    end

    assign out_o   = out_q;
    assign count_o = cnt_q;
    assign null_o  = null_q;

    AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_i && !cfg_wr_i) |=> null_o); // R2

    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_strobe && !out_q && !cfg_wr_i) |=> out_q); // R8

    AST_RATE_LOW_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_RATE && !out_q) |-> (cnt_q == ONE)); // R5

    AST_WAVE_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wave && !gate_lvl && !cfg_wr_i && !load_now) |=> ($stable(cnt_q) && out_q)); // R7

    AST_ONESHOT_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_ONESHOT && loaded_q && cnt_wr_i && !cfg_wr_i && !load_now && cnt_q != ONE)
        |=> (out_q == $past(out_q))); // R4

endmodule

// File: tb/tmr_channel_tb.sv
`timescale 1ns/1ps
// Self-checking bench: per-mode sweeps of small counts with widths computed arithmetically.
module tmr_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gate_i;
    logic        cfg_wr_i;
    logic [2:0]  mode_i;
    logic        bcd_i;
    logic        cnt_wr_i;
    logic [15:0] count_i;
    logic        out_o;
    logic [15:0] count_o;
    logic        null_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tmr_channel u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_i   (gate_i),
        .cfg_wr_i (cfg_wr_i),
        .mode_i   (mode_i),
        .bcd_i    (bcd_i),
        .cnt_wr_i (cnt_wr_i),
        .count_i  (count_i),
        .out_o    (out_o),
        .count_o  (count_o),
        .null_o   (null_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] m, input logic b);
        cfg_wr_i = 1'b1; mode_i = m; bcd_i = b;
        step();
        cfg_wr_i = 1'b0;
    endtask

    task automatic wr(input logic [15:0] v);
        cnt_wr_i = 1'b1; count_i = v;
        step();
        cnt_wr_i = 1'b0;
    endtask

    // Number of clocks until OUT reaches the given level.
    task automatic measure(input logic lvl, input int limit, output int n);
        n = 0;
        while (out_o !== lvl && n < limit) begin
            step();
            n++;
        end
    endtask

    initial begin
        int n, c1, lows;
        rst_n = 1'b0; gate_i = 1'b1; cfg_wr_i = 1'b0; mode_i = 3'd0;
        bcd_i = 1'b0; cnt_wr_i = 1'b0; count_i = 16'd0;
        steps(3);
        rst_n = 1'b1;
        step();
        chk(out_o === 1'b1, "R1 out", out_o, 1);
        chk(count_o === 16'd0, "R1 count", count_o, 0);
        chk(null_o === 1'b0, "R1 null", null_o, 0);

        // R13 and R2: mode 0 config, null flag and live count
        cfg(3'd0, 1'b0);
        chk(out_o === 1'b0, "R13 mode0 initial out", out_o, 0);
        chk(null_o === 1'b1, "R13 null after config", null_o, 1);
        wr(16'd100);
        chk(null_o === 1'b1, "R2 null after write", null_o, 1);
        step();
        chk(null_o === 1'b0, "R2 null after load", null_o, 0);
        chk(count_o === 16'd100, "R2 loaded count", count_o, 100);
        steps(5);
        chk(count_o === 16'd95, "R2 live count", count_o, 95);

        // R3: mode 0 sweep
        for (int nv = 1; nv <= 8; nv++) begin
            cfg(3'd0, 1'b0);
            wr(16'(nv));
            measure(1'b1, 100, n);
            chk(n == nv + 1, "R3 terminal delay", n, nv + 1);
        end
        // R3: gate low pauses mode 0
        cfg(3'd0, 1'b0);
        wr(16'd20);
        steps(5);
        gate_i = 1'b0;
        steps(3);
        c1 = count_o;
        steps(6);
        chk(count_o == 16'(c1), "R3 paused count", count_o, c1);
        chk(out_o === 1'b0, "R3 paused out", out_o, 0);
        gate_i = 1'b1;
        steps(3);

        // R10: decimal stepping
        cfg(3'd0, 1'b1);
        wr(16'h0100);
        step();
        chk(count_o === 16'h0100, "R10 bcd load", count_o, 16'h0100);
        step();
        chk(count_o === 16'h0099, "R10 bcd borrow", count_o, 16'h0099);
        wr(16'h0000);
        steps(2);
        chk(count_o === 16'h9999, "R10 bcd wrap", count_o, 16'h9999);
        cfg(3'd0, 1'b1);
        wr(16'h0012);
        measure(1'b1, 100, n);
        chk(n == 13, "R10 bcd terminal delay", n, 13);

        // R5: rate generator sweep
        cfg(3'd2, 1'b0);
        chk(out_o === 1'b1, "R13 mode2 initial out", out_o, 1);
        for (int nv = 2; nv <= 10; nv++) begin
            cfg(3'd2, 1'b0);
            wr(16'(nv));
            measure(1'b0, 100, n);
            chk(n == nv, "R5 first low", n, nv);
            step();
            chk(out_o === 1'b1, "R5 one-clock low", out_o, 1);
            measure(1'b0, 100, n);
            chk(n == nv - 1, "R5 period", n + 1, nv);
        end
        // R7: gate low on running rate generator, then retrigger
        gate_i = 1'b0;
        steps(3);
        c1 = count_o;
        chk(out_o === 1'b1, "R7 gate low out", out_o, 1);
        steps(6);
        chk(count_o == 16'(c1), "R7 frozen count", count_o, c1);
        chk(out_o === 1'b1, "R7 out held high", out_o, 1);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        chk(n == 12, "R7 reload on gate rise", n, 12);

        // R6: square wave sweep
        for (int nv = 2; nv <= 9; nv++) begin
            cfg(3'd3, 1'b0);
            wr(16'(nv));
            measure(1'b0, 100, n);
            chk(n == 1 + (nv + 1) / 2, "R6 first high", n, 1 + (nv + 1) / 2);
            measure(1'b1, 100, n);
            chk(n == nv / 2, "R6 low half", n, nv / 2);
            measure(1'b0, 100, n);
            chk(n == (nv + 1) / 2, "R6 high half", n, (nv + 1) / 2);
        end

        // R12: codes 6 and 7
        cfg(3'd6, 1'b0);
        wr(16'd5);
        measure(1'b0, 100, n);
        chk(n == 5, "R12 code6 as rate", n, 5);
        cfg(3'd7, 1'b0);
        wr(16'd6);
        measure(1'b0, 100, n);
        chk(n == 4, "R12 code7 first high", n, 4);
        measure(1'b1, 100, n);
        chk(n == 3, "R12 code7 low half", n, 3);

        // R8: software strobe sweep
        for (int nv = 1; nv <= 6; nv++) begin
            cfg(3'd4, 1'b0);
            wr(16'(nv));
            measure(1'b0, 100, n);
            chk(n == nv + 1, "R8 strobe delay", n, nv + 1);
            step();
            chk(out_o === 1'b1, "R8 strobe width", out_o, 1);
            lows = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (out_o !== 1'b1) lows++;
            end
            chk(lows == 0, "R8 single strobe", lows, 0);
        end

        // R4: one-shot
        gate_i = 1'b0;
        cfg(3'd1, 1'b0);
        wr(16'd6);
        steps(4);
        chk(out_o === 1'b1, "R4 no start without trigger", out_o, 1);
        chk(null_o === 1'b1, "R4 count not loaded", null_o, 1);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        chk(n == 3, "R4 trigger latency", n, 3);
        measure(1'b1, 100, n);
        chk(n == 6, "R4 pulse width", n, 6);
        gate_i = 1'b0;
        wr(16'd8);
        steps(3);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        steps(2);
        wr(16'd3);
        measure(1'b1, 100, n);
        chk(n + 3 == 8, "R4 mid-pulse write ignored", n + 3, 8);
        gate_i = 1'b0;
        steps(3);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        measure(1'b1, 100, n);
        chk(n == 3, "R4 new count on next trigger", n, 3);
        gate_i = 1'b0;
        wr(16'd8);
        steps(3);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        step();
        gate_i = 1'b0;
        steps(2);
        gate_i = 1'b1;
        measure(1'b1, 100, n);
        chk(n == 11, "R4 retrigger restarts", n, 11);

        // R9: hardware strobe
        gate_i = 1'b0;
        cfg(3'd5, 1'b0);
        wr(16'd4);
        steps(3);
        chk(out_o === 1'b1, "R9 idle before trigger", out_o, 1);
        gate_i = 1'b1;
        measure(1'b0, 100, n);
        chk(n == 7, "R9 strobe delay", n, 7);
        step();
        chk(out_o === 1'b1, "R9 strobe width", out_o, 1);

        // R11: zero count as maximum
        cfg(3'd2, 1'b0);
        wr(16'd0);
        measure(1'b0, 70000, n);
        chk(n == 65536, "R11 binary zero period", n, 65536);
        cfg(3'd2, 1'b1);
        wr(16'd0);
        measure(1'b0, 12000, n);
        chk(n == 10000, "R11 decimal zero period", n, 10000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule